// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This unit holds the control and status state of one descriptor-driven DMA channel. Software changes the state with a single 32-bit write whose upper half is a per-bit write enable for the lower half. Only the status bits whose enable is set take the new value, and every other bit keeps its value. The same status word reads back on a simple strobed read port. The read data is a 32-bit word with bit 0 as its least significant bit.

The unit drives the run, pause, flush and wake controls to a command engine. It takes the engine's state back through the active, dead and branch-taken bits. Active rises once the channel is running and falls once the engine has drained its in-flight work after run is removed. A fatal error reported by the engine sets the dead bit. Dead then blocks any restart until software clears it with a masked write. The data mover is not part of this unit.

Top module: `dma_chan_ctl`

## Requirements
- R1: While rst_ni is low, every status bit, rd_data_o, run_o, pause_o, flush_o and wake_o are 0.
- R2: A write with wr_en_i high changes status bit n (n in 15..0) only when wr_data_i[n+16] is 1, and the bit then takes wr_data_i[n]. Status bit positions: run 15, pause 14, flush 13, wake 12, dead 11, active 10, branch-taken 8, device status 7..0.
- R3: With rd_en_i high, rd_data_o carries the status word with bits 31..16 and bit 9 reading 0. With rd_en_i low, rd_data_o is 0.
- R4: When run reads 1 and dead reads 0, active reads 1 from the next cycle onward.
- R5: After a write that masks run and flush with values 0, both bits read 0 at once. Active stays 1 while eng_busy_i is high and reads 0 on the cycle after eng_busy_i is seen low.
- R6: A write with mask bits for active, dead, wake, flush, pause and run set and values 0 (0xFC000000) clears those six bits, and run then reads 0. Device status and branch-taken are unchanged.
- R7: Writing wake as 1 raises wake_o for exactly one cycle, after which the bit clears by itself.
- R8: A pulse on eng_dead_i sets dead, and an engine set wins over a same-cycle clearing write. Dead then holds until a masked write clears it. While dead reads 1, active falls once eng_busy_i is low and does not rise again.
- R9: With eng_bt_we_i high, branch-taken loads eng_bt_i, unless the same cycle's write masks branch-taken; the write wins.
- R10: A set flush bit holds while eng_busy_i is high and clears by itself on the cycle after eng_busy_i is seen low.
- R11: run_o, pause_o, flush_o and wake_o always equal the run, pause, flush and wake status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word: enables in 31..16, values in 15..0 |
| rd_en_i | input | 1 | Status read strobe |
| rd_data_o | output | 32 | Status word |
| run_o | output | 1 | Run control to the engine |
| pause_o | output | 1 | Pause control to the engine |
| flush_o | output | 1 | Flush request to the engine |
| wake_o | output | 1 | One-cycle wake pulse to the engine |
| eng_busy_i | input | 1 | Engine has in-flight work |
| eng_dead_i | input | 1 | Engine fatal error pulse |
| eng_bt_we_i | input | 1 | Engine branch-taken update strobe |
| eng_bt_i | input | 1 | Engine branch-taken value |

## Verification
Every status bit is visible on the read port on the cycle after the edge that updated it. A wrongly held or wrongly cleared bit therefore shows up in the very next status read. A missed mask test corrupts a bit the write should have left alone, which the next read exposes. A faulty drain condition leaves active or flush set, or clears them, one cycle off from where busy was seen low. A faulty wake path leaves wake_o high on a second cycle. A priority error between the engine and software shows up as the wrong value of dead or branch-taken right after the colliding cycle.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned DEV_W  = 8;

  localparam int unsigned RUN_B  = 15;
  localparam int unsigned PAUS_B = 14;
  localparam int unsigned FLSH_B = 13;
  localparam int unsigned WAKE_B = 12;
  localparam int unsigned DEAD_B = 11;
  localparam int unsigned ACTV_B = 10;
  localparam int unsigned BT_B   = 8;

  // engine-facing bits
  typedef struct packed {
    logic run;
    logic flush;
    logic wake;
    logic dead;
    logic active;
    logic bt;
  } eng_bits_t;
endpackage

// File: rtl/dma_ctl_swbits.sv
module dma_ctl_swbits #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[g] <= 1'b0;
      else if (we_i && mask_i[g]) q_o[g] <= val_i[g];
    end

    p_masked_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && mask_i[g]) |=> $stable(q_o[g]));
  end
endmodule

// File: rtl/dma_ctl_engbits.sv
module dma_ctl_engbits
  import dma_ctl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  eng_bits_t mask_i,
  input  eng_bits_t val_i,
  input  logic      eng_busy_i,
  input  logic      eng_dead_i,
  input  logic      eng_bt_we_i,
  input  logic      eng_bt_i,
  output eng_bits_t q_o
);
  eng_bits_t wm;
  eng_bits_t d;

  assign wm = we_i ? mask_i : '0;

  always_comb begin
    d = q_o;
    if (wm.run) d.run = val_i.run;

    // flush: software wins, otherwise drains away when engine idles
    if (wm.flush)                     d.flush = val_i.flush;
    else if (q_o.flush && !eng_busy_i) d.flush = 1'b0;

    // wake: one-shot
    d.wake = wm.wake && val_i.wake;

    // dead: engine set dominates
    if (eng_dead_i)   d.dead = 1'b1;
    else if (wm.dead) d.dead = val_i.dead;

    if (wm.active)                  d.active = val_i.active;
    else if (q_o.run && !q_o.dead)  d.active = 1'b1;
    else if (!eng_busy_i)           d.active = 1'b0;

    if (wm.bt)             d.bt = val_i.bt;
    else if (eng_bt_we_i)  d.bt = eng_bt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end

  p_active_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o.run && !q_o.dead && !wm.active) |=> q_o.active);

  p_active_drain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_o.run && !eng_busy_i && !wm.active) |=> !q_o.active);

  p_wake_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o.wake && !(wm.wake && val_i.wake)) |=> !q_o.wake);

  p_dead_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o.dead && !wm.dead) |=> q_o.dead);

  p_dead_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_dead_i |=> q_o.dead);

  p_flush_drain_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o.flush && !eng_busy_i && !wm.flush) |=> !q_o.flush);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              run_o,
  output logic              pause_o,
  output logic              flush_o,
  output logic              wake_o,
  input  logic              eng_busy_i,
  input  logic              eng_dead_i,
  input  logic              eng_bt_we_i,
  input  logic              eng_bt_i
);
  localparam int unsigned SW_W = DEV_W + 1;

  logic [HALF_W-1:0] wmask, wval;
  logic [SW_W-1:0]   sw_mask, sw_val, sw_q;
  eng_bits_t         e_mask, e_val, e_q;
  logic [HALF_W-1:0] status;
  logic              unused_bit9;

  assign wmask = wr_data_i[WORD_W-1:HALF_W];
  assign wval  = wr_data_i[HALF_W-1:0];
  assign unused_bit9 = wmask[9] ^ wval[9];

  assign sw_mask = {wmask[PAUS_B], wmask[DEV_W-1:0]};
  assign sw_val  = {wval[PAUS_B],  wval[DEV_W-1:0]};

  assign e_mask = '{run: wmask[RUN_B], flush: wmask[FLSH_B], wake: wmask[WAKE_B],
                    dead: wmask[DEAD_B], active: wmask[ACTV_B], bt: wmask[BT_B]};
  assign e_val  = '{run: wval[RUN_B], flush: wval[FLSH_B], wake: wval[WAKE_B],
                    dead: wval[DEAD_B], active: wval[ACTV_B], bt: wval[BT_B]};

  dma_ctl_swbits #(.W(SW_W)) u_swbits (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i),
    .mask_i (sw_mask),
    .val_i  (sw_val),
    .q_o    (sw_q)
  );

  dma_ctl_engbits u_engbits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (wr_en_i),
    .mask_i      (e_mask),
    .val_i       (e_val),
    .eng_busy_i  (eng_busy_i),
    .eng_dead_i  (eng_dead_i),
    .eng_bt_we_i (eng_bt_we_i),
    .eng_bt_i    (eng_bt_i),
    .q_o         (e_q)
  );

  always_comb begin
    status          = '0;
    status[RUN_B]   = e_q.run;
    status[PAUS_B]  = sw_q[SW_W-1];
    status[FLSH_B]  = e_q.flush;
    status[WAKE_B]  = e_q.wake;
    status[DEAD_B]  = e_q.dead;
    status[ACTV_B]  = e_q.active;
    status[BT_B]    = e_q.bt;
    status[DEV_W-1:0] = sw_q[DEV_W-1:0];
  end

  assign rd_data_o = rd_en_i ? {{HALF_W{1'b0}}, status} : '0;
  assign run_o   = e_q.run;
  assign pause_o = sw_q[SW_W-1];
  assign flush_o = e_q.flush;
  assign wake_o  = e_q.wake;

  p_run_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wmask[RUN_B] && !wval[RUN_B]) |=> !run_o);

  p_rd_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rd_data_o == '0));
endmodule

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;
  localparam int CLK_P = 10;
  localparam int WDOG  = 5000;

  typedef struct packed {
    logic        wr;
    logic [31:0] d;
    logic        busy;
    logic        dead;
    logic        btwe;
    logic        bt;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h80008000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8000}, // R2 run set
    '{1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h8400}, // R4 active rises
    '{1'b1, 32'h00FF00A5, 1'b1, 1'b0, 1'b0, 1'b0, 16'h84A5}, // R2 device status
    '{1'b1, 32'h40004000, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC4A5}, // R2 pause
    '{1'b1, 32'h0000FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC4A5}, // R2 empty mask
    '{1'b1, 32'h10001000, 1'b1, 1'b0, 1'b0, 1'b0, 16'hD4A5}, // R7 wake
    '{1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC4A5}, // R7 self-clear
    '{1'b0, 32'h00000000, 1'b1, 1'b0, 1'b1, 1'b1, 16'hC5A5}, // R9 engine bt
    '{1'b1, 32'h01000000, 1'b1, 1'b0, 1'b1, 1'b1, 16'hC4A5}, // R9 write wins
    '{1'b1, 32'h20002000, 1'b1, 1'b0, 1'b0, 1'b0, 16'hE4A5}, // R10 flush set
    '{1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 16'hE4A5}, // R10 held while busy
    '{1'b1, 32'hA0000000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h44A5}, // R5 stop
    '{1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h44A5}, // R5 draining
    '{1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h40A5}, // R5 drained
    '{1'b1, 32'h20002000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h60A5}, // R10 flush again
    '{1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h40A5}, // R10 auto clear
    '{1'b1, 32'h80008000, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC0A5}, // R2 run
    '{1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC4A5}, // R4
    '{1'b0, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0, 16'hCCA5}, // R8 dead set
    '{1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC8A5}, // R8 active falls
    '{1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC8A5}, // R8 sticky
    '{1'b1, 32'h08000000, 1'b0, 1'b1, 1'b0, 1'b0, 16'hC8A5}, // R8 engine wins
    '{1'b1, 32'hFC000000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00A5}, // R6 reset request
    '{1'b1, 32'h00FF0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}  // R2 clear device
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b1;
  logic [31:0] rd_data_o;
  logic        run_o, pause_o, flush_o, wake_o;
  logic        eng_busy_i = 1'b0;
  logic        eng_dead_i = 1'b0;
  logic        eng_bt_we_i = 1'b0;
  logic        eng_bt_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  dma_chan_ctl u_dma_chan_ctl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_en_i, .rd_data_o,
    .run_o, .pause_o, .flush_o, .wake_o,
    .eng_busy_i, .eng_dead_i, .eng_bt_we_i, .eng_bt_i
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic wr, logic [31:0] d, logic busy, logic dead,
                       logic btwe, logic bt);
    wr_en_i = wr; wr_data_i = d; eng_busy_i = busy;
    eng_dead_i = dead; eng_bt_we_i = btwe; eng_bt_i = bt;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk_i);
    check("R1 status", rd_data_o, 32'h0);
    check("R1 ctl outputs", {28'h0, run_o, pause_o, flush_o, wake_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].wr, VEC[i].d, VEC[i].busy, VEC[i].dead, VEC[i].btwe, VEC[i].bt);
      @(negedge clk_i);
      check($sformatf("R2 vector %0d status", i), rd_data_o, {16'h0, VEC[i].exp});
      check($sformatf("R11 vector %0d outputs", i),
            {28'h0, run_o, pause_o, flush_o, wake_o},
            {28'h0, VEC[i].exp[15], VEC[i].exp[14], VEC[i].exp[13], VEC[i].exp[12]});
    end

    // R3 reserved bits read 0, read gating
    drive(1'b1, 32'h02000200, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    check("R3 reserved bits", rd_data_o, 32'h0);
    drive(1'b1, 32'h40004000, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    rd_en_i = 1'b0;
    #1;
    check("R3 read gated", rd_data_o, 32'h0);
    rd_en_i = 1'b1;
    #1;
    check("R3 read enabled", rd_data_o, 32'h00004000);

    // R8 dead blocks a restart
    drive(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk_i);
    drive(1'b1, 32'h80008000, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    check("R8 no active while dead", rd_data_o, 32'h0000C800);
    @(negedge clk_i);
    check("R8 still inactive", rd_data_o, 32'h0000C800);
    // clearing dead lets active rise one cycle later (R4)
    drive(1'b1, 32'h08000000, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 dead cleared by write", rd_data_o, 32'h0000C000);
    @(negedge clk_i);
    check("R4 active after dead clear", rd_data_o, 32'h0000C400);

    // R1 asynchronous reset while running
    rst_ni = 1'b0;
    #1;
    check("R1 async reset status", rd_data_o, 32'h0);
    check("R1 async reset outputs", {28'h0, run_o, pause_o, flush_o, wake_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule